// File: doc/BRIEF.md
# Oversampled Serial Receive Path

This block is the receive half of an asynchronous serial port. A free-running enable, `tick16`, pulses sixteen times per bit period. On those ticks the block watches the serial input, `rxLine`. When the line goes from high to low, the block re-checks the line at the middle of the bit to tell a real start bit from a glitch. It then assembles 5 to 8 data bits, least significant bit first. If parity is enabled, the parity bit is checked, and the stop bit is sampled last.

Each finished character is stored in a 64-entry receive FIFO with three flags: parity error, framing error and break. The host reads the oldest entry from a holding view (`rdData` and the three `rd*` flags) and removes it with a one-cycle `rdStrobe`. The block reports whether data is waiting, how many entries are held, whether any held entry carries an error, and a one-cycle pulse whenever a character is lost to a full FIFO.

Top module: `serial_rx_core`

## Requirements
- R1: Reception begins only on a falling edge: one tick samples the line high and the next tick samples it low. A line that stays low after a frame ends yields no further character until it has been seen high again.
- R2: On the eighth tick after the tick that saw the edge, the line is sampled again. If it is high, this is a false start: no character is stored and the receiver waits for a new edge.
- R3: Data bits are sampled every 16 ticks, starting 16 ticks after the mid-start check, least significant bit first. `wordLen` sets the count of data bits: 0 = 5, 1 = 6, 2 = 7, 3 = 8. Unused upper bits of the stored byte read as zero.
- R4: When `parityEn` is 1, one parity bit follows the data. `parityOdd` = 0 selects even parity and 1 selects odd parity. A mismatch sets the stored parity-error flag; with `parityEn` = 0 that flag is always 0.
- R5: The stop bit is sampled 16 ticks after the last data or parity bit. If it is low, the stored framing-error flag is set.
- R6: A character whose data bits, parity bit (if any) and stop bit are all low is stored with both the break flag and the framing-error flag set.
- R7: Characters are stored in a 64-entry FIFO in arrival order, each at the clock edge of its stop-bit sample. `rdData` and the `rd*` flags show the oldest entry. `rdStrobe` removes it at the next edge, and is ignored when the FIFO is empty.
- R8: A character that completes while 64 entries are held, with no read in the same cycle, is discarded. `ovrPulse` is then high for exactly the one following cycle.
- R9: `dataReady` is high exactly when the FIFO holds at least one entry, and `fifoCount` gives the number of entries held.
- R10: `fifoErrAny` is high exactly when at least one held entry has its parity, framing or break flag set.
- R11: After reset the FIFO is empty, `dataReady`, `fifoErrAny` and `ovrPulse` are low, and the receiver waits for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxLine | input | 1 | Serial input, idle high |
| wordLen | input | 2 | Data bit count select (0..3 gives 5..8) |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| rdStrobe | input | 1 | Remove the oldest FIFO entry |
| rdData | output | 8 | Oldest entry's data byte |
| rdParErr | output | 1 | Oldest entry's parity-error flag |
| rdFrmErr | output | 1 | Oldest entry's framing-error flag |
| rdBrk | output | 1 | Oldest entry's break flag |
| dataReady | output | 1 | FIFO not empty |
| fifoCount | output | 7 | Number of entries held |
| fifoErrAny | output | 1 | Some held entry has an error flag |
| ovrPulse | output | 1 | One-cycle pulse when a character is discarded |

## Verification
The assertions check on every cycle the properties that hold at each edge:
- the occupancy never exceeds 64;
- a dropped character leaves a full FIFO full;
- a read of an empty FIFO leaves it empty;
- an error indication only appears while data is held;
- a line found high at the mid-start check returns the receiver to idle;
- the bit index never passes the selected word length.

Only the bench's scenarios can show the rest, where the content of what is stored matters:
- bit order and word-length masking;
- the parity sense;
- framing and break classification;
- rejection of glitches and of a line held low;
- the arrival order of 64 stored characters.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rxState_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic       clrShift;
    logic       capBit;
    logic [2:0] bitPos;
    logic       capPar;
    logic       push;
    logic       lineVal;
  } rxStrobe_t;

  typedef struct packed {
    logic [7:0] data;
    logic       parErr;
    logic       frmErr;
    logic       brk;
  } rxEntry_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick16,
  input  logic            rxLine,
  input  logic [1:0]      wordLen,
  input  logic            parityEn,
  output rxStrobe_t       strb
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rxState_t    state;
  logic [CW-1:0] cnt;
  logic [2:0]  bitIdx;
  logic        prevLine;
  logic [2:0]  lastIdx;
  logic        fullBit;

  assign lastIdx = 3'd4 + {1'b0, wordLen};
  assign fullBit = tick16 && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else if (tick16) begin
      prevLine <= rxLine;
      unique case (state)
        ST_IDLE: begin
          if (prevLine && !rxLine) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == MID) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxLine ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (bitIdx == lastIdx) state <= parityEn ? ST_PAR : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_PAR: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.lineVal  = rxLine;
    strb.bitPos   = bitIdx;
    strb.clrShift = (state == ST_START) && tick16 && (cnt == MID) && !rxLine;
    strb.capBit   = (state == ST_DATA) && fullBit;
    strb.capPar   = (state == ST_PAR) && fullBit;
    strb.push     = (state == ST_STOP) && fullBit;
  end

  // R2: a line found high at the mid-start check abandons the frame
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick16 && cnt == MID && rxLine) |=> (state == ST_IDLE));

  // R3: the bit index stays inside the selected word length
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitIdx <= lastIdx));
endmodule

// File: rtl/rx_data.sv
module rx_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rxStrobe_t                 strb,
  input  logic                      parityEn,
  input  logic                      parityOdd,
  input  logic                      rdStrobe,
  output logic [7:0]                rdData,
  output logic                      rdParErr,
  output logic                      rdFrmErr,
  output logic                      rdBrk,
  output logic                      dataReady,
  output logic [$clog2(DEPTH):0]    fifoCount,
  output logic                      fifoErrAny,
  output logic                      ovrPulse
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [7:0]  shiftData;
  logic        parBit;
  rxEntry_t    mem [DEPTH];
  rxEntry_t    newEnt, headEnt;
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count, errCnt;
  logic        full, pop, accept, newBad, headBad;

  // character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftData <= '0;
      parBit    <= 1'b0;
    end else if (strb.clrShift) begin
      shiftData <= '0;
      parBit    <= 1'b0;
    end else begin
      if (strb.capBit) shiftData[strb.bitPos] <= strb.lineVal;
      if (strb.capPar) parBit <= strb.lineVal;
    end
  end

  always_comb begin
    newEnt.data   = shiftData;
    newEnt.parErr = parityEn && ((^shiftData) ^ parBit ^ parityOdd);
    newEnt.frmErr = !strb.lineVal;
    newEnt.brk    = !strb.lineVal && (shiftData == 8'h00) && !parBit;
  end

  assign full    = (count == FULLV);
  assign pop     = rdStrobe && (count != '0);
  assign accept  = strb.push && (!full || pop);
  assign headEnt = mem[rdPtr];
  assign newBad  = newEnt.parErr | newEnt.frmErr | newEnt.brk;
  assign headBad = headEnt.parErr | headEnt.frmErr | headEnt.brk;

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= newEnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      errCnt   <= '0;
      ovrPulse <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (pop)    rdPtr <= rdPtr + 1'b1;
      count    <= count + (AW+1)'(accept) - (AW+1)'(pop);
      errCnt   <= errCnt + (AW+1)'(accept && newBad) - (AW+1)'(pop && headBad);
      ovrPulse <= strb.push && full && !pop;
    end
  end

  assign rdData     = headEnt.data;
  assign rdParErr   = headEnt.parErr;
  assign rdFrmErr   = headEnt.frmErr;
  assign rdBrk      = headEnt.brk;
  assign dataReady  = (count != '0);
  assign fifoCount  = count;
  assign fifoErrAny = (errCnt != '0);

  // R8: occupancy is bounded by the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULLV);

  // R8: a dropped character leaves the FIFO full
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full && !rdStrobe) |=> (count == FULLV) && ovrPulse);

  // R7: a read of an empty FIFO is ignored
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && count == '0 && !strb.push) |=> (count == '0));

  // R10: an error indication implies stored data
  a_r10_err_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    fifoErrAny |-> (count != '0));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OVS   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick16,
  input  logic                   rxLine,
  input  logic [1:0]             wordLen,
  input  logic                   parityEn,
  input  logic                   parityOdd,
  input  logic                   rdStrobe,
  output logic [7:0]             rdData,
  output logic                   rdParErr,
  output logic                   rdFrmErr,
  output logic                   rdBrk,
  output logic                   dataReady,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic                   fifoErrAny,
  output logic                   ovrPulse
);
  rxStrobe_t strb;

  rx_ctrl #(.OVS(OVS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .wordLen(wordLen), .parityEn(parityEn), .strb(strb)
  );

  rx_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .parityEn(parityEn),
    .parityOdd(parityOdd), .rdStrobe(rdStrobe), .rdData(rdData),
    .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdBrk(rdBrk),
    .dataReady(dataReady), .fifoCount(fifoCount),
    .fifoErrAny(fifoErrAny), .ovrPulse(ovrPulse)
  );
endmodule

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
  localparam int TDIV = 2;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0, rstN = 1'b0, tick16 = 1'b0, rxLine = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic parityEn = 1'b0, parityOdd = 1'b0, rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic rdParErr, rdFrmErr, rdBrk, dataReady, fifoErrAny, ovrPulse;
  logic [6:0] fifoCount;

  int total = 0, bad = 0, ovrSeen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_rx_core u0 (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .wordLen(wordLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdBrk(rdBrk), .dataReady(dataReady),
    .fifoCount(fifoCount), .fifoErrAny(fifoErrAny), .ovrPulse(ovrPulse)
  );

  // tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % TDIV;
    tick16 <= (tdiv == 0);
  end

  // behavioural reference receiver
  typedef struct { int d; bit pe; bit fe; bit bk; } ent_t;
  ent_t q[$];
  int mst = 0, mcnt = 0, mbit = 0, md = 0, mp = 0;
  bit mprev = 1, expOvr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mst = 0; mcnt = 0; mprev = 1; expOvr = 0;
    end else begin
      int szb;
      bit doPop;
      szb    = q.size();
      doPop  = rdStrobe && szb > 0;
      expOvr = 0;
      if (doPop) void'(q.pop_front());
      if (tick16) begin
        bit ln;
        ln = rxLine;
        case (mst)
          0: if (mprev && !ln) begin mst = 1; mcnt = 0; end
          1: if (mcnt == 7) begin
               if (ln) mst = 0;
               else begin mst = 2; mcnt = 0; mbit = 0; md = 0; mp = 0; end
             end else mcnt++;
          2: if (mcnt == 15) begin
               if (ln) md = md | (1 << mbit);
               mcnt = 0;
               if (mbit == 4 + wordLen) mst = parityEn ? 3 : 4; else mbit++;
             end else mcnt++;
          3: if (mcnt == 15) begin mp = ln; mcnt = 0; mst = 4; end else mcnt++;
          default: if (mcnt == 15) begin
               ent_t e;
               int ones;
               ones = 0;
               for (int i = 0; i < 8; i++) ones += (md >> i) & 1;
               e.d  = md;
               e.pe = parityEn && (((ones + mp + parityOdd) % 2) != 0);
               e.fe = !ln;
               e.bk = !ln && md == 0 && mp == 0;
               if (szb == 64 && !doPop) expOvr = 1; else q.push_back(e);
               mcnt = 0; mst = 0;
             end else mcnt++;
        endcase
        mprev = ln;
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit ok, anyErr;
      anyErr = 0;
      foreach (q[i]) if (q[i].pe || q[i].fe || q[i].bk) anyErr = 1;
      ok = (dataReady == (q.size() > 0)) && (fifoCount == q.size()) &&
           (ovrPulse == expOvr) && (fifoErrAny == anyErr);
      if (q.size() > 0)
        ok = ok && rdData == q[0].d[7:0] && rdParErr == q[0].pe &&
             rdFrmErr == q[0].fe && rdBrk == q[0].bk;
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL R7 R9 model: cnt=%0d/%0d data=%h/%h ovr=%0d/%0d err=%0d/%0d",
                 fifoCount, q.size(), rdData, (q.size() > 0) ? q[0].d[7:0] : 8'h0,
                 ovrPulse, expOvr, fifoErrAny, anyErr);
      end
      if (ovrPulse) ovrSeen++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input bit v);
    rxLine = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input int d, input int nb, input bit usePar,
                      input bit parV, input bit stopV);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (usePar) hold_bit(parV);
    hold_bit(stopV);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic pop_one();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  function automatic bit par_of(input int d, input int nb);
    bit p = 0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!dataReady && fifoCount == 0, "R11 empty after reset", fifoCount, 0);
    chk(!fifoErrAny && !ovrPulse, "R11 flags low", {fifoErrAny, ovrPulse}, 0);

    // R3 8 data bits, LSB first
    wordLen = 2'd3;
    send(8'hA5, 8, 0, 0, 1);
    chk(rdData == 8'hA5, "R3 8-bit byte", rdData, 8'hA5);
    chk(dataReady && fifoCount == 1, "R9 ready with one entry", fifoCount, 1);
    pop_one();
    chk(!dataReady, "R9 ready drops after read", dataReady, 0);
    pop_one();
    chk(fifoCount == 0, "R7 read of empty fifo ignored", fifoCount, 0);

    // R3 5 data bits, upper bits zero
    wordLen = 2'd0;
    send(8'h13, 5, 0, 0, 1);
    chk(rdData == 8'h13 && !rdParErr && !rdFrmErr, "R3 5-bit byte", rdData, 8'h13);
    pop_one();

    // R4 even parity, correct
    wordLen = 2'd2; parityEn = 1'b1; parityOdd = 1'b0;
    send(8'h5A, 7, 1, par_of(8'h5A, 7), 1);
    chk(rdData == 8'h5A && !rdParErr, "R4 even parity ok", rdParErr, 0);
    pop_one();
    // R4 odd parity selected, even parity sent -> error
    parityOdd = 1'b1;
    send(8'h35, 7, 1, par_of(8'h35, 7), 1);
    chk(rdParErr == 1'b1, "R4 odd parity mismatch", rdParErr, 1);
    chk(fifoErrAny == 1'b1, "R10 error entry held", fifoErrAny, 1);
    pop_one();
    chk(fifoErrAny == 1'b0, "R10 cleared after read", fifoErrAny, 0);
    // R4 odd parity, correct
    send(8'h35, 7, 1, !par_of(8'h35, 7), 1);
    chk(!rdParErr, "R4 odd parity ok", rdParErr, 0);
    pop_one();

    // R5 framing error
    parityEn = 1'b0; wordLen = 2'd3;
    send(8'h81, 8, 0, 0, 0);
    chk(rdFrmErr && !rdBrk && rdData == 8'h81, "R5 low stop bit", rdFrmErr, 1);
    pop_one();

    // R6 break, line then held low: R1 no second character
    @(negedge clk);
    hold_bit(1'b0);
    repeat (20) hold_bit(1'b0);
    hold_bit(1'b1); hold_bit(1'b1);
    chk(fifoCount == 1, "R1 held-low line gives one character", fifoCount, 1);
    chk(rdBrk && rdFrmErr && rdData == 8'h00, "R6 break flags", {rdBrk, rdFrmErr}, 3);
    pop_one();

    // R2 false start glitch
    @(negedge clk);
    rxLine = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk(!dataReady, "R2 glitch stores nothing", dataReady, 0);
    send(8'h3C, 8, 0, 0, 1);
    chk(rdData == 8'h3C && fifoCount == 1, "R2 valid start after glitch", rdData, 8'h3C);
    pop_one();

    // R8 overrun: 65 characters into 64 entries
    for (int i = 0; i < 65; i++) send(i + 8'h40, 8, 0, 0, 1);
    chk(fifoCount == 64, "R8 fifo full", fifoCount, 64);
    chk(ovrSeen == 1, "R8 one overrun pulse", ovrSeen, 1);
    // R7 order preserved
    for (int i = 0; i < 64; i++) begin
      chk(rdData == 8'(i + 8'h40), "R7 arrival order", rdData, i + 8'h40);
      pop_one();
    end
    chk(!dataReady, "R9 empty after draining", dataReady, 0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule